// File: doc/BRIEF.md
# Paged Two-Wire Management Memory Slave

This block is a two-wire serial slave that gives a host byte-wide access to a management memory of 256 addresses. The host drives the clock line and uses the bidirectional data line to run transfers. A transfer opens with a START condition and closes with a STOP condition. The slave answers a single device address. The host writes a byte pointer and then writes data bytes, or it issues a repeated START and reads bytes back. A burst reads or writes consecutive bytes.

The lower half of the address space (00h to 7Fh) is one fixed page and is always visible. Its first bytes show live monitor and flag values that arrive on a parallel input. Its last byte is a page-select register. The upper half (80h to FFh) is a window onto the upper page that the register selects. Page 00h is a read-only identification page, and pages 02h and 03h are read/write. Page 01h is optional and is left out by default. Pages that are not implemented read as zero and discard writes. The block samples both bus lines with the system clock. It drives the data line only by pulling it low through an output-enable.

Top module: `pmem_twi_slave`

## Requirements
- R1: The slave acknowledges the 7-bit device address 50h, which appears as the byte A0h for a write and A1h for a read. For any other address byte it returns no acknowledge, keeps the data line released until the next START, and then serves a valid transfer normally.
- R2: A write transfer consists of A0h, a pointer byte and data. It stores each data byte at the pointer. Reading the same address later returns that byte. A read is made with A0h, the pointer, a repeated START and then A1h.
- R3: In a read burst the pointer advances after each byte. In the lower half it wraps from 7Fh to 00h. In the upper half it wraps from FFh to 80h.
- R4: A write burst advances the pointer after each byte with the same wrapping as R3, so consecutive bytes land at consecutive addresses.
- R5: Lower bytes 00h to MON_BYTES-1 (00h to 0Fh by default) return monitor byte k = mon_i[8k+7:8k]. Writes to them are acknowledged and have no effect.
- R6: Byte 7Fh is the page-select register, which the host can read and write. A value written to it chooses the upper page for addresses 80h to FFh. The lower half is unaffected by the page choice. A burst may change the page part-way through.
- R7: Upper page 00h is read-only. The byte at offset o (address 80h+o) reads as o XOR 3Ch. Writes to it are acknowledged and discarded.
- R8: Upper pages 02h and 03h are read/write and hold independent contents.
- R9: Page 01h (absent by default) and every page number of 04h or above read as 00h. Writes to them are acknowledged and discarded, and they change no other page.
- R10: When the host does not acknowledge a read byte, the read ends. The slave then releases the data line until the next START.
- R11: The slave changes its data-line drive only while the clock line is low. It never pulls the line low where neither an acknowledge nor read data is due.
- R12: After reset the data line is released, the page register is 00h, and all writable bytes are 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line driven by the host |
| sda_i | input | 1 | Level of the serial data line |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| mon_i | input | MON_BYTES*8 | Live monitor and flag bytes; byte k appears at lower address k |

## Verification
Single-byte writes and reads at a plain lower address show that storage works. Bursts that run across 7Fh and across FFh tell the two wrap rules apart from a flat 8-bit increment. The same upper address is written under several page values. This separates the read/write pages from one another, from the read-only identification page, and from the pages that are not implemented. An address byte that does not match, and a read ended without an acknowledge, are each followed by a check that the line stays released. A valid transfer then shows that the slave has recovered.

// File: rtl/pmem_pkg.sv
// Shared types and helpers for the paged two-wire memory slave.
// Assumes byte-wide storage and an 8-bit byte pointer split into two halves.
package pmem_pkg;

    localparam int unsigned HALF_BYTES = 128;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } twi_state_e;

    // Advance a byte pointer and keep it inside its half of the space.
    function automatic logic [7:0] step_ptr(input logic [7:0] p);
        return {p[7], p[6:0] + 7'd1};
    endfunction

endpackage

// File: rtl/pmem_twi_sync.sv
// Bus line sampler: brings SCL and SDA into the clk domain and flags
// clock edges and START/STOP conditions.
// Assumes the host holds each line level for several clk cycles.
module pmem_twi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES:0] scl_sr;
    logic [STAGES:0] sda_sr;
    logic            scl_old;
    logic            sda_old;

    // Shift both lines through the synchroniser chain; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[STAGES-1:0], scl_i};
            sda_sr <= {sda_sr[STAGES-1:0], sda_i};
        end
    end

    assign scl_lvl_o  = scl_sr[STAGES-1];
    assign sda_lvl_o  = sda_sr[STAGES-1];
    assign scl_old    = scl_sr[STAGES];
    assign sda_old    = sda_sr[STAGES];
    assign scl_rise_o = scl_lvl_o & ~scl_old;
    assign scl_fall_o = ~scl_lvl_o & scl_old;
    assign start_o    = scl_lvl_o & scl_old & sda_old & ~sda_lvl_o;
    assign stop_o     = scl_lvl_o & scl_old & ~sda_old & sda_lvl_o;

endmodule

// File: rtl/pmem_twi_ctrl.sv
// Transfer sequencer: decodes the device address, loads the byte pointer,
// issues one write pulse per received data byte and shifts read data out.
// Assumes edge and condition strobes from pmem_twi_sync. The data line
// changes only on a clock fall.
module pmem_twi_ctrl
    import pmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       sda_lvl,
    input  logic [7:0] rd_data,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] rd_addr_o
);

    twi_state_e state_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    logic [7:0] ptr_q;
    logic       rd_q;
    logic       hack_q;

    assign rd_addr_o = ptr_q;

    // Bit-level sequencer for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            ptr_q     <= '0;
            rd_q      <= 1'b0;
            hack_q    <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (bus_start) begin
                state_q  <= ST_DEV;
                cnt_q    <= '0;
                sda_oe_o <= 1'b0;
            end else if (bus_stop) begin
                state_q  <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state_q)
                    ST_DEV, ST_PTR, ST_WR: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[6:0], sda_lvl};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (state_q == ST_DEV) begin
                                if (sh_q[7:1] == DEV_ADDR) begin
                                    rd_q     <= sh_q[0];
                                    sda_oe_o <= 1'b1;
                                    state_q  <= ST_DEV_ACK;
                                end else begin
                                    state_q  <= ST_SKIP;
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_q    <= sh_q;
                                sda_oe_o <= 1'b1;
                                state_q  <= ST_PTR_ACK;
                            end else begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr_q;
                                wr_data_o <= sh_q;
                                ptr_q     <= step_ptr(ptr_q);
                                sda_oe_o  <= 1'b1;
                                state_q   <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            if (rd_q) begin
                                sh_q     <= rd_data;
                                sda_oe_o <= ~rd_data[7];
                                state_q  <= ST_RD;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state_q  <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            state_q  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                cnt_q    <= '0;
                                sda_oe_o <= 1'b0;
                                ptr_q    <= step_ptr(ptr_q);
                                state_q  <= ST_RD_ACK;
                            end else begin
                                sh_q     <= {sh_q[6:0], 1'b0};
                                sda_oe_o <= ~sh_q[6];
                                cnt_q    <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            hack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (hack_q) begin
                                sh_q     <= rd_data;
                                sda_oe_o <= ~rd_data[7];
                                state_q  <= ST_RD;
                            end else begin
                                state_q  <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pmem_page_ram.sv
// One upper page of byte storage: a single write port and an asynchronous
// read port. It clears to zero on reset.
// Assumes DEPTH is a power of two.
module pmem_page_ram #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    // Clear on reset, otherwise store the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pmem_bank.sv
// Address map: lower fixed page (monitor bytes, scratch bytes and the page
// register) plus a window onto the selected upper page. Pages that are not
// implemented read zero and ignore writes.
// Assumes MON_BYTES is a power of two, between 2 and 64.
module pmem_bank
    import pmem_pkg::*;
#(
    parameter int unsigned MON_BYTES = 16,
    parameter bit          HAS_PAGE1 = 1'b0,
    parameter logic [7:0]  ID_XOR    = 8'h3C,
    localparam int unsigned NUM_PAGES = 4,
    localparam int unsigned MON_W     = $clog2(MON_BYTES),
    localparam int unsigned LOW_FIRST = MON_BYTES,
    localparam int unsigned LOW_LAST  = HALF_BYTES - 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [7:0]             rd_addr,
    input  logic [MON_BYTES*8-1:0] mon_i,
    output logic [7:0]             rd_data
);

    logic [7:0] page_q;
    logic [7:0] low_q [LOW_FIRST:LOW_LAST];
    logic [7:0] up_rd [NUM_PAGES];
    logic [7:0] mon_b [MON_BYTES];
    logic       wr_low;

    genvar gk;
    for (gk = 0; gk < int'(MON_BYTES); gk++) begin : g_mon
        assign mon_b[gk] = mon_i[gk*8 +: 8];
    end

    assign wr_low = wr_en & ~wr_addr[7];

    // Lower page writes: the page register or the scratch bytes; monitor bytes are never written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            for (int i = LOW_FIRST; i <= int'(LOW_LAST); i++) low_q[i] <= '0;
        end else if (wr_low) begin
            if (wr_addr[6:0] == 7'h7F) begin
                page_q <= wr_data;
            end else if (wr_addr[6:0] >= 7'(LOW_FIRST)) begin
                low_q[wr_addr[6:0]] <= wr_data;
            end
        end
    end

    assign up_rd[0] = {1'b0, rd_addr[6:0]} ^ ID_XOR;

    genvar gp;
    for (gp = 1; gp < int'(NUM_PAGES); gp++) begin : g_page
        if (gp != 1 || HAS_PAGE1) begin : g_ram
            pmem_page_ram #(.DEPTH(HALF_BYTES)) u_ram (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_en & wr_addr[7] & (page_q == 8'(gp))),
                .waddr (wr_addr[6:0]),
                .wdata (wr_data),
                .raddr (rd_addr[6:0]),
                .rdata (up_rd[gp])
            );
        end else begin : g_absent
            assign up_rd[gp] = '0;
        end
    end

    // Read mux across both halves of the space.
    always_comb begin
        rd_data = '0;
        if (!rd_addr[7]) begin
            if (rd_addr[6:0] < 7'(MON_BYTES)) rd_data = mon_b[rd_addr[MON_W-1:0]];
            else if (rd_addr[6:0] == 7'h7F)   rd_data = page_q;
            else                              rd_data = low_q[rd_addr[6:0]];
        end else if (page_q < 8'(NUM_PAGES)) begin
            rd_data = up_rd[page_q[1:0]];
        end
    end

endmodule

// File: rtl/pmem_twi_slave.sv
// Top level: paged two-wire management memory slave. It joins the line
// sampler, the transfer sequencer and the address map.
// Assumes an open-drain bus outside the block: sda_oe_o pulls the line low.
module pmem_twi_slave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h50,
    parameter int unsigned MON_BYTES   = 16,
    parameter bit          HAS_PAGE1   = 1'b0,
    parameter logic [7:0]  ID_XOR      = 8'h3C,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [MON_BYTES*8-1:0] mon_i
);

    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    pmem_twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    pmem_twi_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_lvl   (sda_lvl),
        .rd_data   (rd_data),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr)
    );

    pmem_bank #(
        .MON_BYTES (MON_BYTES),
        .HAS_PAGE1 (HAS_PAGE1),
        .ID_XOR    (ID_XOR)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .mon_i   (mon_i),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/pmem_twi_slave_chk.sv
// Property checker for pmem_twi_slave. It watches the bus drive, the
// synchronised clock level and the write port between sequencer and map.
// Assumes it is attached to the top module with the bind below.
module pmem_twi_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_lvl,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] rd_addr
);

    // R12: the line is released in the cycle after any reset cycle.
    a_r12_reset_releases: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

    // R11: the drive never starts while the clock line stays high.
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> !$rose(sda_oe));

    // R4: each received data byte produces exactly one write pulse.
    a_r4_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R2: a byte is written at the pointer that was held before it arrived.
    a_r2_write_at_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr == $past(rd_addr));

    // R4: after a write, the pointer has moved one step inside the same half.
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_addr == {wr_addr[7], wr_addr[6:0] + 7'd1});

endmodule

bind pmem_twi_slave pmem_twi_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe_o),
    .scl_lvl (scl_lvl),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr)
);

// File: tb/pmem_twi_slave_bench.sv
// Bench: a behavioural host drives transfers, and a byte-level memory model
// predicts every acknowledge and read byte. A per-clock monitor checks the
// data-line drive.
module pmem_twi_slave_bench;

    localparam int MONB = 16;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [MONB*8-1:0] mon;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    bit may_drive = 1'b0;
    int grace = 0;

    int m_low [128];
    int m_up [4][128];
    int m_page = 0;
    int wq [$];

    always #5 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    pmem_twi_slave u_pmem_twi_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .mon_i    (mon)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R11/R10: on every clock the slave may pull the line low only where the host allows it.
    always @(negedge clk) begin
        if (rst_n) begin
            nchk++;
            if (sda_oe && !(may_drive || grace > 0)) begin
                nfail++;
                $display("FAIL R11 unexpected drive at %0t: actual 1 expected 0", $time);
            end
            if (may_drive) grace = 5;
            else if (grace > 0) grace--;
        end
    end

    function automatic int mread(input int a);
        if (a < 128) begin
            if (a < MONB) return 'hC0 + a;
            if (a == 127) return m_page;
            return m_low[a];
        end
        case (m_page)
            0: return (a - 128) ^ 'h3C;
            2, 3: return m_up[m_page][a - 128];
            default: return 0;
        endcase
    endfunction

    task automatic mwrite(input int a, input int d);
        if (a < 128) begin
            if (a == 127) m_page = d;
            else if (a >= MONB) m_low[a] = d;
        end else if (m_page == 2 || m_page == 3) begin
            m_up[m_page][a - 128] = d;
        end
    endtask

    function automatic int mstep(input int a);
        if (a < 128) return (a + 1) % 128;
        return 128 + ((a + 1) % 128);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitc(input logic b, input logic md, output logic s);
        sda_h = b;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        s = sda_line;
        tick(Q);
        scl = 1'b0;
        may_drive = md;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_h = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        sda_h = 1'b0;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        sda_h = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic rd_next, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bitc(b[i], i == 0, s);
        bitc(1'b1, rd_next, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bitc(1'b1, 1'b1, s);
            d[i] = s;
        end
        bitc(~ack, ack, s);
    endtask

    task automatic wr_seq(input int addr, input string req);
        logic ack;
        int a = addr;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        check(req, ack, 1, "write address ack");
        send_byte(8'(addr), 1'b0, ack);
        check(req, ack, 1, "pointer ack");
        foreach (wq[k]) begin
            send_byte(8'(wq[k]), 1'b0, ack);
            check(req, ack, 1, "data ack");
            mwrite(a, wq[k]);
            a = mstep(a);
        end
        bus_stop();
        wq.delete();
    endtask

    task automatic rd_seq(input int addr, input int n, input string req);
        logic ack;
        logic s;
        logic [7:0] d;
        int a = addr;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        check(req, ack, 1, "write address ack");
        send_byte(8'(addr), 1'b0, ack);
        check(req, ack, 1, "pointer ack");
        bus_start();
        send_byte(8'hA1, 1'b1, ack);
        check(req, ack, 1, "read address ack");
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check(req, int'(d), mread(a), $sformatf("read byte at %0h", a));
            a = mstep(a);
        end
        // R10: after the final no-acknowledge the line must stay high.
        for (int k = 0; k < 9; k++) begin
            bitc(1'b1, 1'b0, s);
            check("R10", int'(s), 1, "line after nack");
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        for (int k = 0; k < MONB; k++) mon[k*8 +: 8] = 8'(8'hC0 + k);
        for (int i = 0; i < 128; i++) m_low[i] = 0;
        for (int p = 0; p < 4; p++) for (int i = 0; i < 128; i++) m_up[p][i] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check("R12", int'(sda_oe), 0, "line released after reset");
        rd_seq('h7F, 1, "R12");
        rd_seq('h40, 2, "R12");

        // R1: an address byte that does not match gets no ack, and the line stays silent.
        bus_start();
        send_byte(8'hA4, 1'b0, ack);
        check("R1", ack, 0, "foreign address nack");
        send_byte(8'h00, 1'b0, ack);
        check("R1", ack, 0, "silent after foreign address");
        bus_stop();

        wq = '{'h5A}; wr_seq('h40, "R2");
        rd_seq('h40, 1, "R2");

        rd_seq('h00, 4, "R5");
        wq = '{'hFF, 'hEE}; wr_seq('h02, "R5");
        rd_seq('h00, 4, "R5");

        wq = '{'h11, 'h22, 'h33}; wr_seq('h7C, "R4");
        rd_seq('h7D, 4, "R3");

        wq = '{2}; wr_seq('h7F, "R6");
        wq = '{'hA1, 'hA2, 'hA3}; wr_seq('h80, "R8");
        wq = '{3}; wr_seq('h7F, "R6");
        wq = '{'hB1, 'hB2}; wr_seq('h80, "R8");
        rd_seq('h80, 2, "R8");
        wq = '{2}; wr_seq('h7F, "R6");
        rd_seq('h80, 3, "R8");
        rd_seq('h40, 1, "R6");
        rd_seq('h7F, 1, "R6");

        wq = '{3}; wr_seq('h7F, "R6");
        wq = '{'hAA, 'hBB, 'hCC}; wr_seq('hFE, "R4");
        rd_seq('hFF, 2, "R3");

        wq = '{'h77, 0}; wr_seq('h7E, "R6");
        rd_seq('h7E, 1, "R6");
        rd_seq('h80, 3, "R7");
        wq = '{'h12, 'h34}; wr_seq('h80, "R7");
        rd_seq('h80, 2, "R7");

        wq = '{1}; wr_seq('h7F, "R9");
        wq = '{'h55}; wr_seq('h90, "R9");
        rd_seq('h90, 2, "R9");
        wq = '{9}; wr_seq('h7F, "R9");
        wq = '{'h66}; wr_seq('hA0, "R9");
        rd_seq('hA0, 1, "R9");
        wq = '{2}; wr_seq('h7F, "R9");
        rd_seq('h80, 3, "R9");
        rd_seq('h90, 1, "R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule